// File: doc/BRIEF.md
# Descriptor Completion Interrupt Grouper

This block sits beside a host controller's schedule engine and turns per-descriptor completion events into interrupt requests. Three descriptor lists are served (isochronous, interrupt-transfer and asynchronous). Each list has a 32-entry done map that collects completion pulses tagged with the list and the slot index. Two mask registers per list group those completions. The all-of mask raises the list's status once every selected slot is done. The any-of mask raises it as soon as one selected slot is done.

A fourth status source marks each 125 microsecond microframe tick. Status bits are cleared by writing ones to them. Software also clears done-map bits by writing ones. The single interrupt line is the OR of the enabled status bits. It can be held back for a programmable number of microframe ticks, so that several completions arrive with one interrupt.

Top module: `cmpl_irq_grouper`

## Requirements
- R1: A cycle with `done_vld` high sets bit `done_slot` of the done map selected by `done_list`, where code 0 is isochronous, 1 is interrupt-transfer and 2 is asynchronous. The bit is visible on the map output after the next clock edge.
- R2: A cycle with `map_clr_vld` high clears, in the map chosen by `map_clr_list` (same codes as R1), every bit that is one in `map_clr_bits`. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R3: When any bit of a list's map that its any-of mask selects is one, that list's status bit is set one clock edge later.
- R4: When a list's all-of mask is nonzero and every bit it selects is one in that list's map, the list's status bit is set one clock edge later. An all-of mask of zero never sets status.
- R5: The status bits are ordered as bit 0 isochronous, bit 1 interrupt-transfer, bit 2 asynchronous and bit 3 frame-start. A cycle with `utick` high sets bit 3 after that clock edge.
- R6: Writing a one to a bit of `stat_clr` clears that status bit. If the bit's own set condition is true in the same cycle, the bit stays set.
- R7: A status bit drives `irq` only while its bit in `irq_en` is one. A set status bit that is disabled leaves `irq` low.
- R8: With `latency` equal to zero, `irq` is high in every cycle in which an enabled status bit is set.
- R9: With `latency` equal to N greater than zero, `irq` goes high in the cycle after the Nth `utick` that is sampled while an enabled status bit is pending. The tick count returns to zero whenever nothing is pending.
- R10: A completion pulse with list code 3 changes no done map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_vld | input | 1 | Completion pulse |
| done_list | input | 2 | List code of the completion |
| done_slot | input | 5 | Slot index of the completion |
| map_clr_vld | input | 1 | Software done-map clear strobe |
| map_clr_list | input | 2 | List code of the map to clear |
| map_clr_bits | input | 32 | Ones mark the map bits to clear |
| utick | input | 1 | Microframe tick pulse |
| and_mask_iso | input | 32 | All-of mask, isochronous list |
| and_mask_int | input | 32 | All-of mask, interrupt-transfer list |
| and_mask_asy | input | 32 | All-of mask, asynchronous list |
| or_mask_iso | input | 32 | Any-of mask, isochronous list |
| or_mask_int | input | 32 | Any-of mask, interrupt-transfer list |
| or_mask_asy | input | 32 | Any-of mask, asynchronous list |
| latency | input | 8 | Interrupt delay in microframe ticks |
| irq_en | input | 4 | Per-source interrupt enables |
| stat_clr | input | 4 | Write-1-to-clear strobe for status |
| status | output | 4 | Interrupt status register |
| irq | output | 1 | Interrupt request line |
| done_map_iso | output | 32 | Done map, isochronous list |
| done_map_int | output | 32 | Done map, interrupt-transfer list |
| done_map_asy | output | 32 | Done map, asynchronous list |

## Verification
The hardest state to reach is the delayed-interrupt window. It needs a status bit pending and enabled, a nonzero latency, and a run of microframe ticks that are counted only while that status stays set. A status clear in the middle of the window must reset the count. The stimulus first quiets every source, then enables only the frame-start bit and spaces tick pulses apart. It samples the line just before and just after the tick that should release it. A second pass aims at the write-1-to-clear race: status is cleared while the grouping condition still holds, and then again once the done map has been cleared.

// File: rtl/cig_pkg.sv
package cig_pkg;
  localparam int NUM_LISTS = 3;
  localparam int STAT_W    = NUM_LISTS + 1;
  localparam int STAT_SOF  = NUM_LISTS;

  typedef enum logic [1:0] {
    LIST_ISO  = 2'd0,
    LIST_INT  = 2'd1,
    LIST_ASY  = 2'd2,
    LIST_NONE = 2'd3
  } list_e;
endpackage

// File: rtl/cig_done_map.sv
module cig_done_map #(
  parameter int          SLOTS   = 32,
  parameter int          SLOT_W  = $clog2(SLOTS),
  parameter logic [1:0]  LIST_ID = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [1:0]        set_list,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic              clr_vld,
  input  logic [1:0]        clr_list,
  input  logic [SLOTS-1:0]  clr_bits,
  output logic [SLOTS-1:0]  map
);
  logic [SLOTS-1:0] map_q, map_d, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (set_vld && (set_list == LIST_ID)) set_vec = SLOTS'(1) << set_slot;
    if (clr_vld && (clr_list == LIST_ID)) clr_vec = clr_bits;
    // a set in the same cycle as a clear keeps the bit
    map_d = (map_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  assign map = map_q;
endmodule

// File: rtl/cig_group_eval.sv
module cig_group_eval #(
  parameter int SLOTS = 32
) (
  input  logic [SLOTS-1:0] map,
  input  logic [SLOTS-1:0] all_mask,
  input  logic [SLOTS-1:0] any_mask,
  output logic             hit
);
  logic all_hit, any_hit;

  always_comb begin
    all_hit = (|all_mask) && ((map & all_mask) == all_mask);
    any_hit = |(map & any_mask);
    hit     = all_hit || any_hit;
  end
endmodule

// File: rtl/cig_latency_timer.sv
module cig_latency_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic             utick,
  input  logic [LAT_W-1:0] latency,
  output logic             fire
);
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = !pend || (utick && (cnt_q != {LAT_W{1'b1}}));
    cnt_d  = pend ? cnt_q + LAT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign fire = pend && (cnt_q >= latency);
endmodule

// File: rtl/cmpl_irq_grouper.sv
module cmpl_irq_grouper
  import cig_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int LAT_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done_vld,
  input  logic [1:0]            done_list,
  input  logic [SLOT_W-1:0]     done_slot,
  input  logic                  map_clr_vld,
  input  logic [1:0]            map_clr_list,
  input  logic [SLOTS-1:0]      map_clr_bits,
  input  logic                  utick,
  input  logic [SLOTS-1:0]      and_mask_iso,
  input  logic [SLOTS-1:0]      and_mask_int,
  input  logic [SLOTS-1:0]      and_mask_asy,
  input  logic [SLOTS-1:0]      or_mask_iso,
  input  logic [SLOTS-1:0]      or_mask_int,
  input  logic [SLOTS-1:0]      or_mask_asy,
  input  logic [LAT_W-1:0]      latency,
  input  logic [STAT_W-1:0]     irq_en,
  input  logic [STAT_W-1:0]     stat_clr,
  output logic [STAT_W-1:0]     status,
  output logic                  irq,
  output logic [SLOTS-1:0]      done_map_iso,
  output logic [SLOTS-1:0]      done_map_int,
  output logic [SLOTS-1:0]      done_map_asy
);
  logic [SLOTS-1:0]     map_a  [NUM_LISTS];
  logic [SLOTS-1:0]     all_a  [NUM_LISTS];
  logic [SLOTS-1:0]     any_a  [NUM_LISTS];
  logic [NUM_LISTS-1:0] hit;
  logic [STAT_W-1:0]    stat_q, stat_d;
  logic                 pend;

  assign all_a[LIST_ISO] = and_mask_iso;
  assign all_a[LIST_INT] = and_mask_int;
  assign all_a[LIST_ASY] = and_mask_asy;
  assign any_a[LIST_ISO] = or_mask_iso;
  assign any_a[LIST_INT] = or_mask_int;
  assign any_a[LIST_ASY] = or_mask_asy;

  for (genvar g = 0; g < NUM_LISTS; g++) begin : g_list
    cig_done_map #(
      .SLOTS   (SLOTS),
      .SLOT_W  (SLOT_W),
      .LIST_ID (2'(g))
    ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vld  (done_vld),
      .set_list (done_list),
      .set_slot (done_slot),
      .clr_vld  (map_clr_vld),
      .clr_list (map_clr_list),
      .clr_bits (map_clr_bits),
      .map      (map_a[g])
    );

    cig_group_eval #(
      .SLOTS (SLOTS)
    ) u_eval (
      .map      (map_a[g]),
      .all_mask (all_a[g]),
      .any_mask (any_a[g]),
      .hit      (hit[g])
    );
  end

  // status: set condition wins over a write-1 clear
  always_comb begin
    stat_d = (stat_q & ~stat_clr) | {utick, hit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign pend = |(stat_q & irq_en);

  cig_latency_timer #(
    .LAT_W (LAT_W)
  ) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .utick   (utick),
    .latency (latency),
    .fire    (irq)
  );

  assign status       = stat_q;
  assign done_map_iso = map_a[LIST_ISO];
  assign done_map_int = map_a[LIST_INT];
  assign done_map_asy = map_a[LIST_ASY];
endmodule

// File: rtl/cig_checker.sv
module cig_checker #(
  parameter int SLOTS  = 32,
  parameter int LAT_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_vld,
  input logic [1:0]        done_list,
  input logic [SLOT_W-1:0] done_slot,
  input logic              map_clr_vld,
  input logic [1:0]        map_clr_list,
  input logic [SLOTS-1:0]  map_clr_bits,
  input logic              utick,
  input logic [SLOTS-1:0]  and_mask_iso,
  input logic [SLOTS-1:0]  and_mask_int,
  input logic [SLOTS-1:0]  and_mask_asy,
  input logic [SLOTS-1:0]  or_mask_iso,
  input logic [SLOTS-1:0]  or_mask_int,
  input logic [SLOTS-1:0]  or_mask_asy,
  input logic [LAT_W-1:0]  latency,
  input logic [3:0]        irq_en,
  input logic [3:0]        stat_clr,
  input logic [3:0]        status,
  input logic              irq,
  input logic [SLOTS-1:0]  done_map_iso,
  input logic [SLOTS-1:0]  done_map_int,
  input logic [SLOTS-1:0]  done_map_asy
);
  assert_set_iso_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_list == 2'd0) |=> done_map_iso[$past(done_slot)]);

  assert_or_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_map_int & or_mask_int)) |=> status[1]);

  assert_and_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((and_mask_asy != '0) && ((done_map_asy & and_mask_asy) == and_mask_asy)) |=> status[2]);

  assert_frame_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    utick |=> status[3]);

  assert_w1c_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !stat_clr[0]) |=> status[0]);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(status & irq_en)));

  assert_zero_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((latency == '0) && (|(status & irq_en))) |-> irq);

  assert_delay_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((latency != '0) && $rose(|(status & irq_en))) |-> !irq);
endmodule

bind cmpl_irq_grouper cig_checker #(.SLOTS(SLOTS), .LAT_W(LAT_W)) u_chk (.*);

// File: tb/tb_cmpl_irq_grouper.sv
module tb_cmpl_irq_grouper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_vld = 1'b0;
  logic [1:0]  done_list = 2'd0;
  logic [4:0]  done_slot = 5'd0;
  logic        map_clr_vld = 1'b0;
  logic [1:0]  map_clr_list = 2'd0;
  logic [31:0] map_clr_bits = '0;
  logic        utick = 1'b0;
  logic [31:0] and_mask_iso = '0, and_mask_int = '0, and_mask_asy = '0;
  logic [31:0] or_mask_iso = '0, or_mask_int = '0, or_mask_asy = '0;
  logic [7:0]  latency = '0;
  logic [3:0]  irq_en = '0;
  logic [3:0]  stat_clr = '0;
  logic [3:0]  status;
  logic        irq;
  logic [31:0] done_map_iso, done_map_int, done_map_asy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cmpl_irq_grouper dut (.*);

  // behavioural reference model
  logic [31:0] m_map [3];
  logic [3:0]  m_stat;
  int          m_cnt;

  always @(posedge clk) begin
    logic [31:0] am, om, nm [3];
    logic [3:0]  src;
    bit          pend_old;
    if (!rst_n) begin
      for (int l = 0; l < 3; l++) m_map[l] = '0;
      m_stat = '0;
      m_cnt  = 0;
    end else begin
      src = '0;
      for (int l = 0; l < 3; l++) begin
        am = (l == 0) ? and_mask_iso : (l == 1) ? and_mask_int : and_mask_asy;
        om = (l == 0) ? or_mask_iso  : (l == 1) ? or_mask_int  : or_mask_asy;
        if (am != 0 && (m_map[l] & am) == am) src[l] = 1'b1;
        if ((m_map[l] & om) != 0) src[l] = 1'b1;
        nm[l] = m_map[l];
        if (map_clr_vld && map_clr_list == l) nm[l] = nm[l] & ~map_clr_bits;
        if (done_vld && done_list == l) nm[l][done_slot] = 1'b1;
      end
      src[3] = utick;
      pend_old = (m_stat & irq_en) != 0;
      if (!pend_old) m_cnt = 0;
      else if (utick && m_cnt < 255) m_cnt = m_cnt + 1;
      m_stat = (m_stat & ~stat_clr) | src;
      for (int l = 0; l < 3; l++) m_map[l] = nm[l];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit m_irq;
      m_irq = ((m_stat & irq_en) != 0) && (m_cnt >= int'(latency));
      chk("R1 iso map", done_map_iso, m_map[0]);
      chk("R1 int map", done_map_int, m_map[1]);
      chk("R1 asy map", done_map_asy, m_map[2]);
      chk("R5 status", {28'd0, status}, {28'd0, m_stat});
      chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic pulse_done(logic [1:0] lst, logic [4:0] slot);
    done_vld = 1'b1; done_list = lst; done_slot = slot;
    tick();
    done_vld = 1'b0;
  endtask

  task automatic pulse_utick();
    utick = 1'b1;
    tick();
    utick = 1'b0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    at_neg();
    chk("reset status R5", {28'd0, status}, 32'd0);
    chk("reset irq R7", {31'd0, irq}, 32'd0);
    chk("reset map R1", done_map_asy, 32'd0);
    tick();

    // R1: set iso slot 5, async slot 31
    pulse_done(2'd0, 5'd5);
    pulse_done(2'd2, 5'd31);
    at_neg();
    chk("R1 iso slot5", done_map_iso, 32'h0000_0020);
    chk("R1 asy slot31", done_map_asy, 32'h8000_0000);
    tick();

    // R10: list code 3 ignored
    pulse_done(2'd3, 5'd7);
    at_neg();
    chk("R10 iso", done_map_iso, 32'h0000_0020);
    chk("R10 int", done_map_int, 32'h0);
    chk("R10 asy", done_map_asy, 32'h8000_0000);
    tick();

    // R4: zero all-of mask never raises status
    tick(); tick();
    at_neg();
    chk("R4 zero mask", {31'd0, status[0]}, 32'd0);
    tick();

    // R3: any-of on int list
    or_mask_int = 32'h0000_0200;
    pulse_done(2'd1, 5'd9);
    at_neg();
    chk("R3 not yet", {31'd0, status[1]}, 32'd0);
    tick();
    at_neg();
    chk("R3 int status", {31'd0, status[1]}, 32'd1);
    tick();

    // R4: all-of on async list, slots 1 and 2
    and_mask_asy = 32'h0000_0006;
    pulse_done(2'd2, 5'd1);
    tick(); tick();
    at_neg();
    chk("R4 partial", {31'd0, status[2]}, 32'd0);
    tick();
    pulse_done(2'd2, 5'd2);
    tick();
    at_neg();
    chk("R4 complete", {31'd0, status[2]}, 32'd1);
    tick();

    // R6: clear while condition holds keeps bit
    stat_clr = 4'b0100;
    tick();
    stat_clr = 4'b0000;
    at_neg();
    chk("R6 held", {31'd0, status[2]}, 32'd1);
    tick();

    // R2: clear async map bit 1, then status clears
    map_clr_vld = 1'b1; map_clr_list = 2'd2; map_clr_bits = 32'h0000_0002;
    tick();
    map_clr_vld = 1'b0;
    at_neg();
    chk("R2 map cleared", done_map_asy, 32'h8000_0004);
    tick();
    stat_clr = 4'b0100;
    tick();
    stat_clr = 4'b0000;
    at_neg();
    chk("R6 cleared", {31'd0, status[2]}, 32'd0);
    tick();

    // R2: set and clear on same bit in same cycle, set wins
    done_vld = 1'b1; done_list = 2'd0; done_slot = 5'd3;
    map_clr_vld = 1'b1; map_clr_list = 2'd0; map_clr_bits = 32'h0000_0008;
    tick();
    done_vld = 1'b0; map_clr_vld = 1'b0;
    at_neg();
    chk("R2 set wins", done_map_iso, 32'h0000_0028);
    tick();

    // R7: int status set but disabled
    irq_en = 4'b0001;
    tick();
    at_neg();
    chk("R7 disabled", {31'd0, irq}, 32'd0);
    tick();
    // R8: enable int, latency zero
    irq_en = 4'b0010;
    at_neg();
    chk("R8 immediate", {31'd0, irq}, 32'd1);
    tick();

    // quiet everything for latency test
    irq_en = 4'b0000;
    or_mask_int = '0; and_mask_asy = '0;
    tick();
    stat_clr = 4'b1111;
    tick();
    stat_clr = 4'b0000;
    at_neg();
    chk("R6 all clear", {28'd0, status}, 32'd0);
    tick();

    // R9: latency 3 on frame-start
    latency = 8'd3;
    irq_en  = 4'b1000;
    pulse_utick();          // sets frame status, not counted
    tick();
    pulse_utick();          // count 1
    tick();
    pulse_utick();          // count 2
    at_neg();
    chk("R9 before", {31'd0, irq}, 32'd0);
    tick();
    pulse_utick();          // count 3
    at_neg();
    chk("R9 released", {31'd0, irq}, 32'd1);
    tick();
    // R9: clear resets the count
    stat_clr = 4'b1000;
    tick();
    stat_clr = 4'b0000;
    pulse_utick();
    tick();
    pulse_utick();
    at_neg();
    chk("R9 restarted", {31'd0, irq}, 32'd0);
    tick();

    repeat (4) tick();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule